// File: doc/BRIEF.md
# Multicast Hash Receive-Address Filter

This block sits on the receive path of an Ethernet MAC and decides, for each incoming frame, whether the frame is kept. It sees only the destination address, which arrives as six bytes in wire order through a byte-valid strobe. A start-of-frame strobe precedes the bytes. While the bytes stream in, the block folds them into a CRC-32 whose top six bits form a hash index. When the last address byte arrives, the block combines five inputs into one verdict: that index looked up in a 64-bit table, a comparison against the station address, a broadcast test, a group-address test, and the mode bits.

Software keeps the table as a low and a high 32-bit register. Both can be written and read back, so a driver can merge new multicast groups into bits it has already set. The mode bits are checked in this order:
- promiscuous accepts everything;
- a station-address hit is always kept;
- broadcast is kept unless its disable bit is set;
- any other group address is kept when pass-all-multicast is on, or when hash mode is on and the selected table bit is 1.

A controller state machine sequences each frame through three states: IDLE, ADDR and DONE. The transitions are:
- IDLE to ADDR on start-of-frame.
- ADDR to ADDR on start-of-frame, which restarts the frame.
- ADDR to DONE when the last address byte is taken.
- DONE to IDLE when no start-of-frame arrives, or DONE to ADDR when one does.

Top module: `mcast_rx_filter`

## Requirements
- R1: The hash runs a CRC with polynomial 0x04C11DB7 and preset 0xFFFFFFFF over exactly the six address bytes. Each byte is taken bit 0 first. For each bit, the feedback is CRC bit 31 XOR the input bit; the CRC then shifts left by one and is XORed with the polynomial when the feedback is 1. `hash_index` is CRC bits 31:26, with no inversion.
- R2: With hash mode on and the other modes off, a non-broadcast group frame is accepted exactly when its table bit is 1. Index 0..31 selects bit `index` of the low register, and index 32..63 selects bit `index-32` of the high register. With hash mode off, the table has no effect.
- R3: `tbl_wr_en` writes `tbl_wr_data` into the low register (`tbl_wr_sel`=0) or the high register (`tbl_wr_sel`=1). `tbl_rd_data` shows the register chosen by `tbl_rd_sel` in the same cycle.
- R4: In promiscuous mode every frame is accepted.
- R5: A frame whose 48-bit destination equals `station_addr` is accepted whatever the mode bits are. The first received byte is compared with `station_addr[7:0]`, and the last with `station_addr[47:40]`.
- R6: The all-ones broadcast address is accepted when `bcast_disable` is 0. When `bcast_disable` is 1, it is rejected unless promiscuous mode is on.
- R7: A group address has bit 0 of its first received byte set to 1. With pass-all-multicast on, every non-broadcast group frame is accepted.
- R8: An individual address (first byte bit 0 = 0) that is not the station address is rejected when promiscuous mode is off, even if pass-all-multicast and hash mode are on.
- R9: `done` is high for exactly one cycle: the cycle after the clock edge that takes the sixth byte. `accept` and `hash_index` are valid in that cycle and hold their values until the next result.
- R10: `sof` reloads the CRC preset and restarts the byte count, even in the middle of a frame. Cycles with `byte_valid` low inside a frame are skipped. Bytes that arrive after the sixth byte and before the next `sof` are ignored.
- R11: After reset, `done`, `accept`, `hash_index` and both table registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start-of-frame strobe |
| byte_valid | input | 1 | `byte_data` holds an address byte |
| byte_data | input | 8 | Destination address byte, in wire order |
| station_addr | input | 48 | Own address; byte 0 is in bits 7:0 |
| mode_promisc | input | 1 | Accept every frame |
| mode_all_mcast | input | 1 | Accept every group frame |
| mode_hash_en | input | 1 | Filter group frames through the hash table |
| bcast_disable | input | 1 | Reject broadcast frames |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_sel | input | 1 | Write target: 0 = low half, 1 = high half |
| tbl_wr_data | input | 32 | Table write data |
| tbl_rd_sel | input | 1 | Read select: 0 = low half, 1 = high half |
| tbl_rd_data | output | 32 | Table readback |
| done | output | 1 | One-cycle result strobe |
| accept | output | 1 | Frame verdict |
| hash_index | output | 6 | Hash index of the last frame |

## Verification
The bench builds the block with its default parameters: six address bytes, two 32-bit table halves and the standard CRC-32 polynomial and preset. With these values, index 31 and index 32 fall in different table halves. The bench searches at run time for group addresses whose hash lands in each half, so it can show that a bit set in one half never accepts a frame that maps to the other half. The six-byte length also allows a frame to be cut off after three bytes and restarted, so the test can confirm that the CRC reloads its preset instead of carrying over the partial result.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DONE = 2'd2
    } flt_state_e;
endpackage

// File: rtl/rxf_crc_hash.sv
`timescale 1ns/1ps
module rxf_crc_hash #(
    parameter logic [31:0] POLY   = 32'h04C11DB7,
    parameter logic [31:0] PRESET = 32'hFFFFFFFF,
    parameter int          IDX_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     step,
    input  logic [rxf_pkg::BYTE_W-1:0] din,
    output logic [IDX_W-1:0]         idx_next
);
    logic [31:0] crc_q;
    logic [31:0] crc_nxt;

    // Fold one byte into the register, bit 0 first.
    always_comb begin
        logic [31:0] c;
        logic        fb;
        c = crc_q;
        for (int b = 0; b < rxf_pkg::BYTE_W; b++) begin
            fb = c[31] ^ din[b];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ POLY;
        end
        crc_nxt = c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= PRESET;
        else if (load) crc_q <= PRESET;
        else if (step) crc_q <= crc_nxt;
    end

    // Index of the value that includes the byte being taken now.
    assign idx_next = crc_nxt[31 -: IDX_W];
endmodule

// File: rtl/rxf_hash_table.sv
`timescale 1ns/1ps
module rxf_hash_table #(
    parameter int HALF_W = 32,
    parameter int IDX_W  = $clog2(2 * HALF_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [HALF_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_bit
);
    localparam int SUB_W = IDX_W - 1;

    logic [HALF_W-1:0] half_val [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q <= '0;
            else if (wr_en && (wr_sel == 1'(h))) q <= wr_data;
        end
        assign half_val[h] = q;
    end

    logic [SUB_W-1:0] sub_idx;
    assign sub_idx = lk_idx[SUB_W-1:0];

    assign rd_data = half_val[rd_sel];
    assign lk_bit  = half_val[lk_idx[IDX_W-1]][sub_idx];
endmodule

// File: rtl/rxf_ctrl_fsm.sv
`timescale 1ns/1ps
module rxf_ctrl_fsm #(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 6,
    localparam int ADDR_W    = ADDR_BYTES * rxf_pkg::BYTE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sof,
    input  logic                       byte_valid,
    input  logic [rxf_pkg::BYTE_W-1:0] byte_data,
    input  logic [ADDR_W-1:0]          station_addr,
    input  logic                       mode_promisc,
    input  logic                       mode_all_mcast,
    input  logic                       mode_hash_en,
    input  logic                       bcast_disable,
    input  logic [IDX_W-1:0]           idx_in,
    input  logic                       tbl_bit,
    output logic                       crc_load,
    output logic                       crc_step,
    output logic                       done,
    output logic                       accept,
    output logic [IDX_W-1:0]           hash_index
);
    import rxf_pkg::*;

    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam int LAST  = ADDR_BYTES - 1;

    flt_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              take_byte, take_last;
    logic [ADDR_W-1:0] full_addr;
    logic              is_group, is_bcast, stn_hit, verdict;
    logic              accept_q;
    logic [IDX_W-1:0]  hash_q;

    assign take_byte = (state_q == ST_ADDR) && byte_valid && !sof;
    assign take_last = take_byte && (cnt_q == CNT_W'(LAST));
    assign crc_load  = sof;
    assign crc_step  = take_byte;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sof) state_d = ST_ADDR;
            ST_ADDR: begin
                if (sof)            state_d = ST_ADDR;
                else if (take_last) state_d = ST_DONE;
            end
            ST_DONE: state_d = sof ? ST_ADDR : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Byte counter and address capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else if (sof) begin
            cnt_q  <= '0;
        end else if (take_byte) begin
            cnt_q  <= cnt_q + CNT_W'(1);
            addr_q[cnt_q*BYTE_W +: BYTE_W] <= byte_data;
        end
    end

    // Decision on the full address, the last byte taken straight from the input
    always_comb begin
        full_addr = addr_q;
        full_addr[LAST*BYTE_W +: BYTE_W] = byte_data;
        is_group = full_addr[0];
        is_bcast = &full_addr;
        stn_hit  = (full_addr == station_addr);
        verdict  = mode_promisc
                 | stn_hit
                 | (is_bcast & ~bcast_disable)
                 | (is_group & ~is_bcast & (mode_all_mcast | (mode_hash_en & tbl_bit)));
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
            hash_q   <= '0;
        end else if (take_last) begin
            accept_q <= verdict;
            hash_q   <= idx_in;
        end
    end

    // Outputs
    always_comb begin
        done       = (state_q == ST_DONE);
        accept     = accept_q;
        hash_index = hash_q;
    end
endmodule

// File: rtl/mcast_rx_filter.sv
`timescale 1ns/1ps
module mcast_rx_filter #(
    parameter int          ADDR_BYTES = 6,
    parameter int          TBL_HALF_W = 32,
    parameter logic [31:0] CRC_POLY   = 32'h04C11DB7,
    parameter logic [31:0] CRC_PRESET = 32'hFFFFFFFF,
    localparam int         IDX_W      = $clog2(2 * TBL_HALF_W),
    localparam int         ADDR_W     = ADDR_BYTES * rxf_pkg::BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sof,
    input  logic                  byte_valid,
    input  logic [7:0]            byte_data,
    input  logic [ADDR_W-1:0]     station_addr,
    input  logic                  mode_promisc,
    input  logic                  mode_all_mcast,
    input  logic                  mode_hash_en,
    input  logic                  bcast_disable,
    input  logic                  tbl_wr_en,
    input  logic                  tbl_wr_sel,
    input  logic [TBL_HALF_W-1:0] tbl_wr_data,
    input  logic                  tbl_rd_sel,
    output logic [TBL_HALF_W-1:0] tbl_rd_data,
    output logic                  done,
    output logic                  accept,
    output logic [IDX_W-1:0]      hash_index
);
    logic             crc_load, crc_step;
    logic [IDX_W-1:0] idx_next;
    logic             tbl_bit;

    rxf_crc_hash #(
        .POLY   (CRC_POLY),
        .PRESET (CRC_PRESET),
        .IDX_W  (IDX_W)
    ) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (crc_load),
        .step     (crc_step),
        .din      (byte_data),
        .idx_next (idx_next)
    );

    rxf_hash_table #(
        .HALF_W (TBL_HALF_W),
        .IDX_W  (IDX_W)
    ) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_sel  (tbl_wr_sel),
        .wr_data (tbl_wr_data),
        .rd_sel  (tbl_rd_sel),
        .rd_data (tbl_rd_data),
        .lk_idx  (idx_next),
        .lk_bit  (tbl_bit)
    );

    rxf_ctrl_fsm #(
        .ADDR_BYTES (ADDR_BYTES),
        .IDX_W      (IDX_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sof            (sof),
        .byte_valid     (byte_valid),
        .byte_data      (byte_data),
        .station_addr   (station_addr),
        .mode_promisc   (mode_promisc),
        .mode_all_mcast (mode_all_mcast),
        .mode_hash_en   (mode_hash_en),
        .bcast_disable  (bcast_disable),
        .idx_in         (idx_next),
        .tbl_bit        (tbl_bit),
        .crc_load       (crc_load),
        .crc_step       (crc_step),
        .done           (done),
        .accept         (accept),
        .hash_index     (hash_index)
    );
endmodule

// File: rtl/rxf_filter_checker.sv
`timescale 1ns/1ps
module rxf_filter_checker #(
    parameter int HALF_W = 32,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sof,
    input logic              byte_valid,
    input logic              mode_promisc,
    input logic              tbl_wr_en,
    input logic              tbl_wr_sel,
    input logic [HALF_W-1:0] tbl_wr_data,
    input logic              tbl_rd_sel,
    input logic [HALF_W-1:0] tbl_rd_data,
    input logic              done,
    input logic              accept,
    input logic [IDX_W-1:0]  hash_index
);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(byte_valid) && !$past(sof)));

    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(accept) && $stable(hash_index)));

    a_r4_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mode_promisc)) |-> accept);

    a_r3_table_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tbl_wr_en) && (tbl_rd_sel == $past(tbl_wr_sel)))
            |-> (tbl_rd_data == $past(tbl_wr_data)));

    a_r10_sof_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !done);
endmodule

bind mcast_rx_filter rxf_filter_checker #(
    .HALF_W (TBL_HALF_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof          (sof),
    .byte_valid   (byte_valid),
    .mode_promisc (mode_promisc),
    .tbl_wr_en    (tbl_wr_en),
    .tbl_wr_sel   (tbl_wr_sel),
    .tbl_wr_data  (tbl_wr_data),
    .tbl_rd_sel   (tbl_rd_sel),
    .tbl_rd_data  (tbl_rd_data),
    .done         (done),
    .accept       (accept),
    .hash_index   (hash_index)
);

// File: tb/sim_mcast_rx_filter.sv
`timescale 1ns/1ps
module sim_mcast_rx_filter;
    localparam logic [31:0] POLY   = 32'h04C11DB7;
    localparam logic [31:0] PRESET = 32'hFFFFFFFF;
    localparam logic [47:0] STN    = 48'h5634_12EF_CD02;
    localparam logic [47:0] BCAST  = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0, byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        mode_promisc = 1'b0, mode_all_mcast = 1'b0, mode_hash_en = 1'b0, bcast_disable = 1'b0;
    logic        tbl_wr_en = 1'b0, tbl_wr_sel = 1'b0, tbl_rd_sel = 1'b0;
    logic [31:0] tbl_wr_data = '0;
    logic [31:0] tbl_rd_data;
    logic        done, accept;
    logic [5:0]  hash_index;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    mcast_rx_filter u0 (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_valid(byte_valid), .byte_data(byte_data),
        .station_addr(STN), .mode_promisc(mode_promisc), .mode_all_mcast(mode_all_mcast),
        .mode_hash_en(mode_hash_en), .bcast_disable(bcast_disable),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_sel(tbl_wr_sel), .tbl_wr_data(tbl_wr_data),
        .tbl_rd_sel(tbl_rd_sel), .tbl_rd_data(tbl_rd_data),
        .done(done), .accept(accept), .hash_index(hash_index)
    );

    task automatic check_val(input string req, input string what,
                             input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Model: bits taken in order a[0], a[1], ... a[47]
    function automatic logic [5:0] ref_index(input logic [47:0] a);
        logic [31:0] r = PRESET;
        for (int i = 0; i < 48; i++) begin
            logic f = r[31] ^ a[i];
            r = r << 1;
            if (f) r = r ^ POLY;
        end
        return r[31:26];
    endfunction

    function automatic logic tbl_pick(input logic [5:0] ix, input logic [31:0] lo, input logic [31:0] hi);
        return (ix >= 6'd32) ? hi[ix - 6'd32] : lo[ix];
    endfunction

    task automatic tbl_write(input logic sel, input logic [31:0] val);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_sel = sel; tbl_wr_data = val;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic set_modes(input logic p, input logic m, input logic h, input logic bd);
        mode_promisc = p; mode_all_mcast = m; mode_hash_en = h; bcast_disable = bd;
    endtask

    task automatic run_frame(input logic [47:0] a, input int gap,
                             output logic acc, output logic [5:0] ix);
        @(negedge clk);
        sof = 1'b1; byte_valid = 1'b0;
        @(negedge clk);
        sof = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (i > 0) begin
                for (int g = 0; g < gap; g++) begin
                    byte_valid = 1'b0;
                    @(negedge clk);
                end
            end
            byte_valid = 1'b1;
            byte_data  = a[i*8 +: 8];
            @(negedge clk);
        end
        byte_valid = 1'b0;
        check_val("R9", "done after sixth byte", 64'(done), 64'd1);
        acc = accept;
        ix  = hash_index;
        @(negedge clk);
        check_val("R9", "done one cycle only", 64'(done), 64'd0);
        check_val("R9", "accept held", 64'(accept), 64'(acc));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_val("R11", "done after reset", 64'(done), 64'd0);
        check_val("R11", "accept after reset", 64'(accept), 64'd0);
        check_val("R11", "hash_index after reset", 64'(hash_index), 64'd0);
        tbl_rd_sel = 1'b0; #1;
        check_val("R11", "low table after reset", 64'(tbl_rd_data), 64'd0);
        tbl_rd_sel = 1'b1; #1;
        check_val("R11", "high table after reset", 64'(tbl_rd_data), 64'd0);
    endtask

    task automatic t_table();
        tbl_write(1'b0, 32'hA5A5_0F0F);
        tbl_write(1'b1, 32'h1234_5678);
        tbl_rd_sel = 1'b0; #1;
        check_val("R3", "low readback", 64'(tbl_rd_data), 64'hA5A5_0F0F);
        tbl_rd_sel = 1'b1; #1;
        check_val("R3", "high readback", 64'(tbl_rd_data), 64'h1234_5678);
        tbl_write(1'b0, 32'h0);
        tbl_write(1'b1, 32'h0);
        tbl_rd_sel = 1'b0; #1;
        check_val("R3", "low cleared", 64'(tbl_rd_data), 64'd0);
    endtask

    task automatic t_crc();
        logic acc; logic [5:0] ix;
        logic [47:0] list [4] = '{BCAST, 48'h0, STN, 48'h9A78_5634_1201};
        set_modes(1'b1, 1'b0, 1'b0, 1'b0);
        foreach (list[k]) begin
            run_frame(list[k], 0, acc, ix);
            check_val("R1", "hash index", 64'(ix), 64'(ref_index(list[k])));
        end
        set_modes(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_hash();
        logic acc; logic [5:0] ix;
        logic [47:0] a_lo = '0, a_hi = '0;
        bit got_lo = 0, got_hi = 0;
        for (int k = 1; k < 4096 && !(got_lo && got_hi); k++) begin
            logic [47:0] c = 48'h01 | (48'(k) << 8);
            if (!got_lo && ref_index(c) < 6'd32) begin a_lo = c; got_lo = 1; end
            if (!got_hi && ref_index(c) >= 6'd32) begin a_hi = c; got_hi = 1; end
        end
        set_modes(1'b0, 1'b0, 1'b1, 1'b0);
        run_frame(a_lo, 0, acc, ix);
        check_val("R2", "low-half addr, empty table", 64'(acc), 64'd0);
        // low half only: bit for a_lo
        tbl_write(1'b0, 32'h1 << ref_index(a_lo));
        run_frame(a_lo, 0, acc, ix);
        check_val("R2", "low-half addr, bit set", 64'(acc), 64'd1);
        run_frame(a_hi, 0, acc, ix);
        check_val("R2", "high-half addr vs low-only table", 64'(acc),
                  64'(tbl_pick(ref_index(a_hi), 32'h1 << ref_index(a_lo), 32'h0)));
        tbl_write(1'b0, 32'h0);
        tbl_write(1'b1, 32'h1 << (ref_index(a_hi) - 6'd32));
        run_frame(a_hi, 0, acc, ix);
        check_val("R2", "high-half addr, bit set", 64'(acc), 64'd1);
        run_frame(a_lo, 0, acc, ix);
        check_val("R2", "low-half addr vs high-only table", 64'(acc),
                  64'(tbl_pick(ref_index(a_lo), 32'h0, 32'h1 << (ref_index(a_hi) - 6'd32))));
        set_modes(1'b0, 1'b0, 1'b0, 1'b0);
        run_frame(a_hi, 0, acc, ix);
        check_val("R2", "hash mode off ignores table", 64'(acc), 64'd0);
        tbl_write(1'b1, 32'h0);
    endtask

    task automatic t_modes();
        logic acc; logic [5:0] ix;
        logic [47:0] other = 48'h0102_0304_0506;   // individual, not station
        logic [47:0] grp   = 48'h7766_5544_3301;   // group
        set_modes(1'b1, 1'b0, 1'b0, 1'b0);
        run_frame(other, 0, acc, ix);
        check_val("R4", "promisc accepts individual", 64'(acc), 64'd1);
        set_modes(1'b0, 1'b0, 1'b0, 1'b0);
        run_frame(STN, 0, acc, ix);
        check_val("R5", "station hit, modes off", 64'(acc), 64'd1);
        run_frame(STN ^ 48'h0100_0000_0000, 0, acc, ix);
        check_val("R8", "near-station individual rejected", 64'(acc), 64'd0);
        run_frame(BCAST, 0, acc, ix);
        check_val("R6", "broadcast accepted", 64'(acc), 64'd1);
        tbl_write(1'b0, 32'hFFFF_FFFF);
        tbl_write(1'b1, 32'hFFFF_FFFF);
        set_modes(1'b0, 1'b1, 1'b1, 1'b1);
        run_frame(BCAST, 0, acc, ix);
        check_val("R6", "broadcast disabled", 64'(acc), 64'd0);
        set_modes(1'b1, 1'b0, 1'b0, 1'b1);
        run_frame(BCAST, 0, acc, ix);
        check_val("R6", "disabled broadcast under promisc", 64'(acc), 64'd1);
        set_modes(1'b0, 1'b1, 1'b1, 1'b0);
        run_frame(other, 0, acc, ix);
        check_val("R8", "individual rejected with mcast modes", 64'(acc), 64'd0);
        tbl_write(1'b0, 32'h0);
        tbl_write(1'b1, 32'h0);
        set_modes(1'b0, 1'b1, 1'b0, 1'b0);
        run_frame(grp, 0, acc, ix);
        check_val("R7", "all-mcast accepts group", 64'(acc), 64'd1);
        set_modes(1'b0, 1'b0, 1'b0, 1'b0);
        run_frame(grp, 0, acc, ix);
        check_val("R7", "group rejected with modes off", 64'(acc), 64'd0);
    endtask

    task automatic t_restart();
        logic acc; logic [5:0] ix; logic [5:0] held;
        logic [47:0] a = 48'hC0FF_EE12_3457;
        // partial frame, then a fresh one
        @(negedge clk); sof = 1'b1;
        @(negedge clk); sof = 1'b0;
        for (int i = 0; i < 3; i++) begin
            byte_valid = 1'b1; byte_data = 8'h3C + 8'(i);
            @(negedge clk);
            check_val("R10", "no done on partial frame", 64'(done), 64'd0);
        end
        byte_valid = 1'b0;
        run_frame(a, 0, acc, ix);
        check_val("R10", "index after restart", 64'(ix), 64'(ref_index(a)));
        run_frame(a, 3, acc, ix);
        check_val("R10", "index with idle gaps", 64'(ix), 64'(ref_index(a)));
        held = ix;
        for (int i = 0; i < 8; i++) begin
            byte_valid = 1'b1; byte_data = 8'h90 + 8'(i);
            @(negedge clk);
            check_val("R10", "stray byte gives no done", 64'(done), 64'd0);
        end
        byte_valid = 1'b0;
        check_val("R10", "index unchanged by stray bytes", 64'(hash_index), 64'(held));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_table();
        t_crc();
        t_hash();
        t_modes();
        t_restart();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule